// File: doc/BRIEF.md
# Serial Programming-Mode Memory Access Port

This block is the device-side slave that lets an external programmer read and write an on-chip program memory while the chip sits in its programming mode. The programmer supplies a serial clock and a data line. It also supplies an active-low strobe that starts each memory access. All traffic moves in 8-bit transfers, least-significant bit first. The first transfer is a command. Address, data and read-back transfers follow, as that command defines.

The block runs on the system clock and oversamples the serial clock, the data line and the strobe through synchronizers. It latches data bits on serial-clock rising edges and launches read-back bits on falling edges. A strobe falling edge starts a single-cycle write or read on a synchronous memory port. Read data is captured into an internal latch and shifted out over the next 16 serial clocks once the strobe has been released. The data pin is presented as a separate output value and output enable, so the pad ring can build the tri-state driver.

Top module: `sp_prog_if`

## Requirements
- R1: After reset, or one cycle after `prog_mode_i` goes low, `sda_oe_o`, `mem_we_o` and `mem_re_o` are 0, and the next byte received is taken as a command.
- R2: Each transfer is 8 bits, least-significant bit first. Input bits are taken from `sda_i` at serial-clock rising edges.
- R3: Command byte 0x15 selects read, 0x25 selects program and 0x35 selects program-verify. Any other byte is ignored: no memory access follows, and the next byte is again decoded as a command.
- R4: Transfer 2 is the low address byte and transfer 3 is the high address byte. `mem_addr_o` is {high[2:0], low}, so bits 7..3 of the high byte have no effect.
- R5: For read, a strobe falling edge after the address produces exactly one `mem_re_o` pulse. After the strobe rises, the stored word is output over 16 serial clocks, low byte first, LSB first, with each bit launched on a falling edge.
- R6: For program, transfers 4 and 5 carry the low and high data bytes. The next strobe falling edge produces exactly one `mem_we_o` pulse with that address and word.
- R7: For program-verify, the same write happens, followed by one `mem_re_o` pulse. After the strobe rises, the word now stored at that address is output over 16 serial clocks.
- R8: `sda_oe_o` stays 0 until the first serial-clock falling edge of the output phase. It returns to 0 after the 16th rising edge of that phase.
- R9: While the block waits for the strobe to fall or to rise, serial-clock edges have no effect. This includes an edge in the same cycle as a strobe edge.
- R10: `mem_we_o` and `mem_re_o` are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_mode_i | input | 1 | Programming mode enable; low forces idle |
| sclk_i | input | 1 | Serial clock from programmer |
| sda_i | input | 1 | Data pin input value |
| pgm_ni | input | 1 | Active-low access strobe |
| sda_o | output | 1 | Data pin output value |
| sda_oe_o | output | 1 | Data pin output enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write pulse |
| mem_re_o | output | 1 | Memory read pulse (data valid next cycle) |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A serial-clock edge and a strobe edge can reach the sequencer in the same system-clock cycle, because both pass through synchronizers of equal depth. The bench provokes this by dropping the strobe and raising the serial clock on the same cycle while a read waits for its access. It then adds further serial pulses before releasing the strobe. The scoreboard judges the case by the read pulse count and the captured address. It also checks that the 16 bits that follow match the stored word with no shift in alignment.

// File: rtl/sp_prog_pkg.sv
package sp_prog_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [7:0] {
    CMD_READ = 8'h15,
    CMD_PROG = 8'h25,
    CMD_VRFY = 8'h35
  } cmd_e;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_ADR_L,
    ST_ADR_H,
    ST_DAT,
    ST_STROBE,
    ST_WR,
    ST_RD,
    ST_LATCH,
    ST_RELEASE,
    ST_TX
  } state_e;

  function automatic logic is_cmd(input logic [7:0] b);
    return (b == CMD_READ) || (b == CMD_PROG) || (b == CMD_VRFY);
  endfunction
endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){IDLE}};
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/sp_rx_byte.sv
module sp_rx_byte
  import sp_prog_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              sclk_rise_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  // same depth as the clock synchronizer keeps data aligned with the edge
  logic [STAGES-1:0] sda_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_q <= '0;
    else         sda_q <= {sda_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      byte_o <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (en_i && sclk_rise_i) begin
        byte_o <= {sda_q[STAGES-1], byte_o[BYTE_W-1:1]};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W-1)) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_tx_word.sv
module sp_tx_word #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              en_i,
  input  logic              sclk_fall_i,
  input  logic              sclk_rise_i,
  output logic              sda_o,
  output logic              oe_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic [CNT_W-1:0]  rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      fcnt_q <= '0;
      rcnt_q <= '0;
      sda_o  <= 1'b0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      fcnt_q <= '0;
      rcnt_q <= '0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        word_q <= word_i;
        fcnt_q <= '0;
        rcnt_q <= '0;
      end else if (en_i) begin
        if (sclk_fall_i) begin
          oe_o   <= 1'b1;
          sda_o  <= word_q[fcnt_q];
          fcnt_q <= fcnt_q + 1'b1;
        end
        // rises before the first launched bit are not counted
        if (sclk_rise_i && oe_o) begin
          if (rcnt_q == CNT_W'(DATA_W-1)) begin
            oe_o   <= 1'b0;
            done_o <= 1'b1;
            rcnt_q <= '0;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sp_prog_if.sv
module sp_prog_if
  import sp_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_i,
  input  logic              sclk_i,
  input  logic              sda_i,
  input  logic              pgm_ni,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned DBYTES = DATA_W / BYTE_W;
  localparam int unsigned DIDX_W = (DBYTES > 1) ? $clog2(DBYTES) : 1;
  localparam int unsigned AHI_W  = ADDR_W - BYTE_W;

  logic sclk_rise, sclk_fall, pgm_rise, pgm_fall;
  logic rx_en, rx_clr, rx_done;
  logic [BYTE_W-1:0] rx_byte;
  logic tx_done;

  state_e            state_q;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DIDX_W-1:0] didx_q;

  sp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_pgm_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pgm_ni),
    .rise_o(pgm_rise), .fall_o(pgm_fall)
  );

  assign rx_en  = (state_q == ST_CMD) || (state_q == ST_ADR_L) ||
                  (state_q == ST_ADR_H) || (state_q == ST_DAT);
  assign rx_clr = !prog_mode_i || !rx_en;

  sp_rx_byte #(.STAGES(SYNC_STAGES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rx_clr), .en_i(rx_en),
    .sclk_rise_i(sclk_rise), .sda_i(sda_i),
    .byte_o(rx_byte), .done_o(rx_done)
  );

  sp_tx_word #(.DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!prog_mode_i),
    .load_i(state_q == ST_LATCH), .word_i(mem_rdata_i),
    .en_i(state_q == ST_TX), .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .sda_o(sda_o), .oe_o(sda_oe_o), .done_o(tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cmd_q   <= CMD_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      didx_q  <= '0;
    end else if (!prog_mode_i) begin
      state_q <= ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_done && is_cmd(rx_byte)) begin
          cmd_q   <= cmd_e'(rx_byte);
          state_q <= ST_ADR_L;
        end
        ST_ADR_L: if (rx_done) begin
          addr_q[BYTE_W-1:0] <= rx_byte;
          state_q            <= ST_ADR_H;
        end
        ST_ADR_H: if (rx_done) begin
          addr_q[ADDR_W-1:BYTE_W] <= rx_byte[AHI_W-1:0];
          didx_q                  <= '0;
          state_q                 <= (cmd_q == CMD_READ) ? ST_STROBE : ST_DAT;
        end
        ST_DAT: if (rx_done) begin
          wdata_q[didx_q*BYTE_W +: BYTE_W] <= rx_byte;
          didx_q                           <= didx_q + 1'b1;
          if (didx_q == DIDX_W'(DBYTES-1)) state_q <= ST_STROBE;
        end
        ST_STROBE: if (pgm_fall) state_q <= (cmd_q == CMD_READ) ? ST_RD : ST_WR;
        ST_WR:      state_q <= (cmd_q == CMD_PROG) ? ST_RELEASE : ST_RD;
        ST_RD:      state_q <= ST_LATCH;
        ST_LATCH:   state_q <= ST_RELEASE;
        ST_RELEASE: if (pgm_rise) state_q <= (cmd_q == CMD_PROG) ? ST_CMD : ST_TX;
        ST_TX:      if (tx_done) state_q <= ST_CMD;
        default:    state_q <= ST_CMD;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_re_o    = (state_q == ST_RD);
endmodule

// File: rtl/sp_prog_if_chk.sv
module sp_prog_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic prog_mode_i,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic sda_oe_o,
  input logic sclk_rise,
  input logic sclk_fall
);
  // R10
  we_re_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R6
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R5
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  // R8
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(sclk_fall));

  // R8
  oe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> ($past(sclk_rise) || !$past(prog_mode_i)));

  // R1
  mode_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_mode_i |=> (!sda_oe_o && !mem_we_o && !mem_re_o));
endmodule

bind sp_prog_if sp_prog_if_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_mode_i(prog_mode_i),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .sda_oe_o(sda_oe_o),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
);

// File: tb/sp_prog_if_tb_top.sv
module sp_prog_if_tb_top;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int HALF   = 8;

  logic clk = 1'b0, rst_ni = 1'b0, prog_mode = 1'b0;
  logic sclk = 1'b0, sda_in = 1'b0, pgm_n = 1'b1;
  logic sda_o, sda_oe_o, mem_we_o, mem_re_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o, mem_rdata;

  logic [DATA_W-1:0] mem [2**ADDR_W];
  logic [DATA_W-1:0] exp_rd[$];
  logic [ADDR_W+DATA_W-1:0] exp_wr[$];
  int checks = 0, failures = 0;
  int re_cnt = 0, we_cnt = 0;
  logic [ADDR_W-1:0] last_re_addr = '0;
  logic [DATA_W-1:0] mon_word = '0;
  int mon_bits = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sp_prog_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .prog_mode_i(prog_mode), .sclk_i(sclk),
    .sda_i(sda_in), .pgm_ni(pgm_n), .sda_o(sda_o), .sda_oe_o(sda_oe_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < 2**ADDR_W; i++) mem[i] = DATA_W'(i * 16'h9E37) ^ 16'h5A5A;

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata <= mem[mem_addr_o];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor: R6/R7 scoreboard
  always @(negedge clk) begin
    if (mem_re_o) begin re_cnt++; last_re_addr = mem_addr_o; end
    if (mem_we_o) begin
      we_cnt++;
      if (exp_wr.size() == 0) chk(0, "R6 unexpected write", int'({mem_addr_o, mem_wdata_o}), 0);
      else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_wr.pop_front();
        chk({mem_addr_o, mem_wdata_o} == e, "R6 write", int'({mem_addr_o, mem_wdata_o}), int'(e));
      end
    end
  end

  // read-back monitor: R5/R7/R2 scoreboard, samples at serial rising edges
  always @(posedge sclk) begin
    if (sda_oe_o && prog_mode) begin
      mon_word[mon_bits] = sda_o;
      mon_bits++;
      if (mon_bits == DATA_W) begin
        mon_bits = 0;
        if (exp_rd.size() == 0) chk(0, "R5 unexpected word", int'(mon_word), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_rd.pop_front();
          chk(mon_word == e, "R5 R2 readback", int'(mon_word), int'(e));
        end
      end
    end else mon_bits = 0;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sda_in = b[i];
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic strobe(input bit low);
    @(negedge clk) pgm_n = !low;
    wait_clk(12);
  endtask

  // output phase: one lead-in rise, then 16 fall/rise pairs
  task automatic read_out(input string req);
    chk(sda_oe_o == 1'b0, {req, " oe before first fall"}, sda_oe_o, 0);
    @(negedge clk) sclk = 1'b1; wait_clk(HALF);
    for (int k = 0; k < DATA_W; k++) begin
      sclk = 1'b0; wait_clk(HALF);
      if (k == 0) chk(sda_oe_o == 1'b1, {req, " oe after first fall"}, sda_oe_o, 1);
      sclk = 1'b1; wait_clk(HALF);
    end
    sclk = 1'b0; wait_clk(HALF);
    chk(sda_oe_o == 1'b0, {req, " oe after 16th rise"}, sda_oe_o, 0);
  endtask

  task automatic do_read(input logic [7:0] lo, input logic [7:0] hi, input string req);
    logic [ADDR_W-1:0] a;
    int r0;
    a = {hi[2:0], lo};
    r0 = re_cnt;
    send_byte(8'h15); send_byte(lo); send_byte(hi);
    strobe(1);
    chk(re_cnt == r0 + 1, {req, " one read pulse"}, re_cnt - r0, 1);
    chk(last_re_addr == a, {req, " R4 address"}, int'(last_re_addr), int'(a));
    exp_rd.push_back(mem[a]);
    strobe(0);
    read_out(req);
  endtask

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk(sda_oe_o == 0 && mem_we_o == 0 && mem_re_o == 0, "R1 reset idle",
        int'({sda_oe_o, mem_we_o, mem_re_o}), 0);
    prog_mode = 1'b1;
    wait_clk(4);

    // R5 R2 R4 plain read
    do_read(8'h23, 8'h01, "R5");
    // R4 upper bits of high address byte ignored
    do_read(8'h40, 8'hFD, "R4");

    // R6 program
    begin
      int w0;
      w0 = we_cnt;
      exp_wr.push_back({11'h7AA, 16'hBEEF});
      send_byte(8'h25); send_byte(8'hAA); send_byte(8'h07);
      send_byte(8'hEF); send_byte(8'hBE);
      strobe(1);
      chk(we_cnt == w0 + 1, "R6 one write pulse", we_cnt - w0, 1);
      strobe(0);
      chk(sda_oe_o == 1'b0, "R6 no output after program", sda_oe_o, 0);
      do_read(8'hAA, 8'h07, "R6 readback");
    end

    // R7 program-verify
    begin
      int w0, r0;
      w0 = we_cnt; r0 = re_cnt;
      exp_wr.push_back({11'h011, 16'h1357});
      send_byte(8'h35); send_byte(8'h11); send_byte(8'h00);
      send_byte(8'h57); send_byte(8'h13);
      strobe(1);
      chk(we_cnt == w0 + 1 && re_cnt == r0 + 1, "R7 write then read",
          (we_cnt - w0) * 16 + (re_cnt - r0), 17);
      exp_rd.push_back(16'h1357);
      strobe(0);
      read_out("R7");
    end

    // R3 unknown command ignored
    begin
      int w0, r0;
      w0 = we_cnt; r0 = re_cnt;
      send_byte(8'h44);
      strobe(1); strobe(0);
      chk(we_cnt == w0 && re_cnt == r0, "R3 no access on bad cmd",
          (we_cnt - w0) + (re_cnt - r0), 0);
      chk(sda_oe_o == 1'b0, "R3 pin stays released", sda_oe_o, 0);
      do_read(8'h02, 8'h00, "R3 next cmd");
    end

    // R9 serial edge coincident with strobe edge during the wait
    begin
      int r0;
      r0 = re_cnt;
      send_byte(8'h15); send_byte(8'h33); send_byte(8'h03);
      @(negedge clk) begin pgm_n = 1'b0; sclk = 1'b1; end
      wait_clk(HALF); sclk = 1'b0;
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
      wait_clk(HALF);
      chk(re_cnt == r0 + 1, "R9 read pulse", re_cnt - r0, 1);
      chk(last_re_addr == 11'h333, "R9 address", int'(last_re_addr), 'h333);
      exp_rd.push_back(mem[11'h333]);
      strobe(0);
      read_out("R9");
    end

    // R1 leaving programming mode mid output
    begin
      send_byte(8'h15); send_byte(8'h55); send_byte(8'h00);
      strobe(1); strobe(0);
      @(negedge clk) sclk = 1'b1; wait_clk(HALF);
      for (int k = 0; k < 5; k++) begin
        sclk = 1'b0; wait_clk(HALF);
        sclk = 1'b1; wait_clk(HALF);
      end
      @(negedge clk) prog_mode = 1'b0;
      wait_clk(2);
      chk(sda_oe_o == 1'b0, "R1 released on mode exit", sda_oe_o, 0);
      sclk = 1'b0;
      wait_clk(6);
      prog_mode = 1'b1;
      wait_clk(4);
      do_read(8'h56, 8'h00, "R1 after mode exit");
    end

    wait_clk(20);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R5 R6 scoreboard drained",
        exp_rd.size() + exp_wr.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule